// File: doc/BRIEF.md
# ATA Device-Side Event Trace Recorder

This block sits on the device end of a parallel ATA interface and keeps an ordered trace of what happens on the wire, for use during board bring-up. It decodes host register accesses from the two chip selects, the three address lines and the read and write strobes. From these it recognises hardware resets, soft resets, command writes, PIO data phases in either direction, interrupt assertion and the return to idle. Each recognised event becomes one 12-bit entry in a small first-in first-out log, which a local debug port drains one entry at a time.

A minimal device model is built in so the traces are real. It answers a write-sectors command by taking one 256-word sector into a buffer. It answers a read-sectors command by handing the same words back. It raises the interrupt at the end of a write when the host has left interrupts enabled.

Top module: `ata_trace_rec`

## Requirements
- R1: A falling edge on the hardware reset input `hrstN` logs one entry of type 1 with argument 0. It also returns the device to idle and clears both Device Control bits.
- R2: A host write to Device Control (CS1- active, DA=6) that changes SRST (bit 2) from 0 to 1 logs one entry of type 2. Writing that bit while it is already 1 logs nothing.
- R3: The command 30h (written with CS0- active, DA=7) logs this sequence: type 3 with argument 30h, then type 4 (host-to-device PIO), then type 6 (interrupt, only when nIEN is 0), then type 7 (idle).
- R4: The command 20h logs this sequence: type 3 with argument 20h, then type 5 (device-to-host PIO), then type 7. No interrupt entry is logged.
- R5: After the last word of a write phase, `intrq` goes high only if nIEN (Device Control bit 1) is 0. With nIEN at 1, neither the pin nor the log shows an interrupt. A status read (CS0-, DA=7) drops `intrq`.
- R6: The 256 words written on the data port (CS0-, DA=0) during a write-sectors phase come back in the same order, unchanged, during the following read-sectors phase.
- R7: The status byte, read on `ddOut[7:0]`, has BSY at bit 7, DRDY at bit 6 (the inverse of BSY) and DRQ at bit 3. DRQ is 1 throughout a data phase. Status reads 40h when the device is idle.
- R8: Any command code other than 20h and 30h logs type 3 with that code as argument, then type 7. It moves no data.
- R9: The log holds 16 entries. When it is full, new entries are dropped and the oldest ones are kept. A drop sets `logOverflow`, which stays set until the system reset `rstN`.
- R10: Each entry is `{type[11:8], argument[7:0]}`. The argument is zero for every type except 3. The log presents its oldest entry on `logData` while `logValid` is high, and `logRdEn` removes that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low system reset; clears the log and the overflow flag |
| hrstN | input | 1 | Active-low ATA hardware reset from the host |
| cs0N | input | 1 | Active-low chip select for the command block |
| cs1N | input | 1 | Active-low chip select for the control block |
| da | input | 3 | Register address |
| diowN | input | 1 | Active-low write strobe; the write is taken at its falling edge |
| diorN | input | 1 | Active-low read strobe; the read completes at its rising edge |
| ddIn | input | 16 | Data bus from the host |
| ddOut | output | 16 | Data bus to the host |
| ddOe | output | 1 | High while the device drives `ddOut` |
| intrq | output | 1 | Interrupt request to the host |
| logRdEn | input | 1 | Removes the oldest log entry |
| logData | output | 12 | Oldest log entry |
| logValid | output | 1 | The log holds at least one entry |
| logOverflow | output | 1 | Sticky flag: an entry was dropped |

## Verification
The write and read commands are run with random sector contents. Each run is made once with interrupts enabled and once with them masked. This separates a missing or misplaced interrupt entry from a fault in the data path, and the random words catch buffer address slips. Random command codes other than 20h and 30h confirm that the code reaches the argument field and that such commands go straight to idle. An overflow burst mixes soft and hard resets, so the order of the surviving entries shows whether the oldest or the newest entries were kept.

// File: rtl/ata_trace_pkg.sv
package ata_trace_pkg;
  localparam int TYPE_W  = 4;
  localparam int ARG_W   = 8;
  localparam int ENTRY_W = TYPE_W + ARG_W;

  localparam logic [7:0] CMD_WR_SECT = 8'h30;
  localparam logic [7:0] CMD_RD_SECT = 8'h20;

  typedef enum logic [TYPE_W-1:0] {
    EV_NONE    = 4'd0,
    EV_HRST    = 4'd1,
    EV_SRST    = 4'd2,
    EV_CMD     = 4'd3,
    EV_PIO_H2D = 4'd4,
    EV_PIO_D2H = 4'd5,
    EV_INTRQ   = 4'd6,
    EV_IDLE    = 4'd7
  } evType_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             logPush;
    evType_t          logType;
    logic [ARG_W-1:0] logArg;
    logic             ptrClr;
    logic             ptrInc;
    logic             bufWe;
  } ctrlStrobes_t;
endpackage

// File: rtl/ata_trace_ctrl.sv
module ata_trace_ctrl
  import ata_trace_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hrstN,
  input  logic         cs0N,
  input  logic         cs1N,
  input  logic [2:0]   da,
  input  logic         diowN,
  input  logic         diorN,
  input  logic [7:0]   ddLow,
  input  logic         ptrLast,
  output ctrlStrobes_t strb,
  output logic [7:0]   statusByte,
  output logic         rdSelData,
  output logic         ddOe,
  output logic         intrq
);
  typedef enum logic [2:0] {
    S_IDLE, S_PIO_W, S_WDATA, S_INT, S_PIO_R, S_RDATA, S_DONE
  } devState_t;

  devState_t state, nextState;
  logic prevW, prevR, prevH;
  logic nIen, srstBit, intPend;
  logic wrFall, rdRise, hrstFall;
  logic selCmd, selData, selCtl;
  logic ctlWr, srstSet, cmdAccept, statusRdDone, intSet;
  logic bsy, drq;

  assign wrFall   = prevW & ~diowN;
  assign rdRise   = ~prevR & diorN;
  assign hrstFall = prevH & ~hrstN;

  assign selCmd  = ~cs0N & cs1N & (da == 3'd7);
  assign selData = ~cs0N & cs1N & (da == 3'd0);
  assign selCtl  = cs0N & ~cs1N & (da == 3'd6);

  assign ctlWr        = selCtl & wrFall & hrstN;
  assign srstSet      = ctlWr & ddLow[2] & ~srstBit;
  assign statusRdDone = selCmd & rdRise;

  always_comb begin
    strb      = '0;
    nextState = state;
    cmdAccept = 1'b0;
    intSet    = 1'b0;
    if (!hrstN) begin
      nextState   = S_IDLE;
      strb.ptrClr = 1'b1;
      if (hrstFall) begin
        strb.logPush = 1'b1;
        strb.logType = EV_HRST;
      end
    end else if (srstSet) begin
      nextState    = S_IDLE;
      strb.ptrClr  = 1'b1;
      strb.logPush = 1'b1;
      strb.logType = EV_SRST;
    end else begin
      unique case (state)
        S_IDLE: if (selCmd && wrFall) begin
          cmdAccept    = 1'b1;
          strb.logPush = 1'b1;
          strb.logType = EV_CMD;
          strb.logArg  = ddLow;
          strb.ptrClr  = 1'b1;
          if (ddLow == CMD_WR_SECT)      nextState = S_PIO_W;
          else if (ddLow == CMD_RD_SECT) nextState = S_PIO_R;
          else                           nextState = S_DONE;
        end
        S_PIO_W: begin
          strb.logPush = 1'b1;
          strb.logType = EV_PIO_H2D;
          nextState    = S_WDATA;
        end
        S_WDATA: if (selData && wrFall) begin
          strb.bufWe  = 1'b1;
          strb.ptrInc = 1'b1;
          if (ptrLast) begin
            intSet    = ~nIen;
            nextState = nIen ? S_DONE : S_INT;
          end
        end
        S_INT: begin
          strb.logPush = 1'b1;
          strb.logType = EV_INTRQ;
          nextState    = S_DONE;
        end
        S_PIO_R: begin
          strb.logPush = 1'b1;
          strb.logType = EV_PIO_D2H;
          nextState    = S_RDATA;
        end
        S_RDATA: if (selData && rdRise) begin
          strb.ptrInc = 1'b1;
          if (ptrLast) nextState = S_DONE;
        end
        S_DONE: begin
          strb.logPush = 1'b1;
          strb.logType = EV_IDLE;
          nextState    = S_IDLE;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      prevW   <= 1'b1;
      prevR   <= 1'b1;
      prevH   <= 1'b1;
      nIen    <= 1'b0;
      srstBit <= 1'b0;
      intPend <= 1'b0;
    end else begin
      state <= nextState;
      prevW <= diowN;
      prevR <= diorN;
      prevH <= hrstN;
      if (!hrstN) begin
        nIen    <= 1'b0;
        srstBit <= 1'b0;
        intPend <= 1'b0;
      end else begin
        if (ctlWr) begin
          nIen    <= ddLow[1];
          srstBit <= ddLow[2];
        end
        if (srstSet || cmdAccept || statusRdDone) intPend <= 1'b0;
        else if (intSet)                          intPend <= 1'b1;
      end
    end
  end

  assign bsy        = (state == S_PIO_W) || (state == S_PIO_R) || (state == S_INT);
  assign drq        = (state == S_WDATA) || (state == S_RDATA);
  assign statusByte = {bsy, ~bsy, 2'b00, drq, 3'b000};
  assign rdSelData  = selData;
  assign ddOe       = ~diorN & (selData | selCmd);
  assign intrq      = intPend & ~nIen;

  // R10
  arg_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.logPush && strb.logType != EV_CMD) |-> (strb.logArg == 8'h00));
  // R5
  int_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_INT) |-> intPend);
  // R7
  idle_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.logPush && strb.logType == EV_IDLE) |-> (statusByte[7] == 1'b0 && statusByte[3] == 1'b0));
  // R3
  pio_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PIO_W) |-> $past(strb.logPush && strb.logType == EV_CMD));
endmodule

// File: rtl/ata_trace_dp.sv
module ata_trace_dp
  import ata_trace_pkg::*;
#(
  parameter int SECT_WORDS = 256,
  parameter int LOG_DEPTH  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [15:0]        ddIn,
  input  logic [7:0]         statusByte,
  input  logic               rdSelData,
  input  logic               logRdEn,
  output logic               ptrLast,
  output logic [15:0]        ddOut,
  output logic [ENTRY_W-1:0] logData,
  output logic               logValid,
  output logic               logOverflow
);
  localparam int PTR_W = $clog2(SECT_WORDS);
  localparam int LPTR_W = $clog2(LOG_DEPTH);
  localparam int CNT_W = $clog2(LOG_DEPTH + 1);

  logic [15:0]        secBuf [SECT_WORDS];
  logic [PTR_W-1:0]   wordPtr;
  logic [ENTRY_W-1:0] logMem [LOG_DEPTH];
  logic [LPTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]   logCnt;
  logic               pop, pushOk;

  assign ptrLast = (wordPtr == PTR_W'(SECT_WORDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordPtr <= '0;
    else if (strb.ptrClr) wordPtr <= '0;
    else if (strb.ptrInc) wordPtr <= wordPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.bufWe) secBuf[wordPtr] <= ddIn;
  end

  assign ddOut = rdSelData ? secBuf[wordPtr] : {8'h00, statusByte};

  assign pop    = logRdEn && (logCnt != '0);
  assign pushOk = strb.logPush && ((logCnt != CNT_W'(LOG_DEPTH)) || pop);

  always_ff @(posedge clk) begin
    if (pushOk) logMem[wrPtr] <= {strb.logType, strb.logArg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      logCnt      <= '0;
      logOverflow <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (pop)    rdPtr <= rdPtr + 1'b1;
      logCnt <= logCnt + CNT_W'(pushOk) - CNT_W'(pop);
      if (strb.logPush && !pushOk) logOverflow <= 1'b1;
    end
  end

  assign logData  = logMem[rdPtr];
  assign logValid = (logCnt != '0);

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    logCnt <= CNT_W'(LOG_DEPTH));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    logOverflow |=> logOverflow);
  // R9
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.logPush && logCnt == CNT_W'(LOG_DEPTH) && !logRdEn) |=> (logOverflow && $stable(wrPtr)));
  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrInc && !strb.ptrClr) |=> (wordPtr == $past(wordPtr) + 1'b1));
endmodule

// File: rtl/ata_trace_rec.sv
module ata_trace_rec
  import ata_trace_pkg::*;
#(
  parameter int SECT_WORDS = 256,
  parameter int LOG_DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hrstN,
  input  logic        cs0N,
  input  logic        cs1N,
  input  logic [2:0]  da,
  input  logic        diowN,
  input  logic        diorN,
  input  logic [15:0] ddIn,
  output logic [15:0] ddOut,
  output logic        ddOe,
  output logic        intrq,
  input  logic        logRdEn,
  output logic [11:0] logData,
  output logic        logValid,
  output logic        logOverflow
);
  ctrlStrobes_t strb;
  logic [7:0]   statusByte;
  logic         rdSelData, ptrLast;

  ata_trace_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .hrstN(hrstN), .cs0N(cs0N), .cs1N(cs1N), .da(da),
    .diowN(diowN), .diorN(diorN), .ddLow(ddIn[7:0]), .ptrLast(ptrLast),
    .strb(strb), .statusByte(statusByte), .rdSelData(rdSelData),
    .ddOe(ddOe), .intrq(intrq)
  );

  ata_trace_dp #(.SECT_WORDS(SECT_WORDS), .LOG_DEPTH(LOG_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ddIn(ddIn), .statusByte(statusByte),
    .rdSelData(rdSelData), .logRdEn(logRdEn), .ptrLast(ptrLast), .ddOut(ddOut),
    .logData(logData), .logValid(logValid), .logOverflow(logOverflow)
  );
endmodule

// File: tb/ata_trace_rec_tb.sv
module ata_trace_rec_tb_top;
  logic clk = 1'b0;
  logic rstN, hrstN, cs0N, cs1N, diowN, diorN, logRdEn;
  logic [2:0]  da;
  logic [15:0] ddIn, ddOut;
  logic ddOe, intrq, logValid, logOverflow;
  logic [11:0] logData;

  int checks = 0;
  int errors = 0;
  logic [15:0] wdata [256];
  logic [11:0] got [32];
  logic [11:0] exp [32];
  int gotN;

  always #10 clk = ~clk;

  ata_trace_rec dut_i (
    .clk(clk), .rstN(rstN), .hrstN(hrstN), .cs0N(cs0N), .cs1N(cs1N), .da(da),
    .diowN(diowN), .diorN(diorN), .ddIn(ddIn), .ddOut(ddOut), .ddOe(ddOe),
    .intrq(intrq), .logRdEn(logRdEn), .logData(logData), .logValid(logValid),
    .logOverflow(logOverflow)
  );

  function automatic logic [11:0] ent(input logic [3:0] t, input logic [7:0] a);
    return {t, a};
  endfunction

  function automatic logic [15:0] expStatus(input logic bsy, input logic drq);
    return {8'h00, bsy, ~bsy, 2'b00, drq, 3'b000};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic regWrite(input bit ctlBlk, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs0N = ctlBlk; cs1N = ~ctlBlk; da = a; ddIn = d; diowN = 1'b0;
    @(negedge clk); @(negedge clk);
    diowN = 1'b1;
    @(negedge clk);
    cs0N = 1'b1; cs1N = 1'b1;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cs0N = 1'b0; cs1N = 1'b1; da = a; diorN = 1'b0;
    @(negedge clk);
    d = ddOut;
    diorN = 1'b1;
    @(negedge clk);
    cs0N = 1'b1;
  endtask

  task automatic drain();
    gotN = 0;
    repeat (4) @(negedge clk);
    while (logValid && gotN < 32) begin
      got[gotN] = logData;
      gotN++;
      logRdEn = 1'b1;
      @(negedge clk);
      logRdEn = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic cmpLog(input string tag, input int n);
    chk({tag, " entry count"}, 32'(gotN), 32'(n));
    for (int i = 0; i < n && i < gotN; i++) chk({tag, " entry"}, 32'(got[i]), 32'(exp[i]));
  endtask

  task automatic hrstPulse();
    @(negedge clk); hrstN = 1'b0;
    repeat (3) @(negedge clk);
    hrstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeSector(input bit masked);
    logic [15:0] s;
    for (int i = 0; i < 256; i++) wdata[i] = 16'($urandom());
    regWrite(1'b1, 3'd6, masked ? 16'h0002 : 16'h0000);
    regWrite(1'b0, 3'd7, 16'h0030);
    repeat (3) @(negedge clk);
    regRead(3'd7, s);
    chk("R7 DRQ during write phase", 32'(s), 32'(expStatus(1'b0, 1'b1)));
    for (int i = 0; i < 256; i++) regWrite(1'b0, 3'd0, wdata[i]);
    repeat (4) @(negedge clk);
    chk("R5 intrq after write phase", 32'(intrq), masked ? 32'd0 : 32'd1);
  endtask

  task automatic readSector(input string tag);
    logic [15:0] s;
    int bad = 0;
    regWrite(1'b0, 3'd7, 16'h0020);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      regRead(3'd0, s);
      if (s !== wdata[i]) begin
        bad++;
        if (bad == 1) chk({tag, " first mismatching word"}, 32'(s), 32'(wdata[i]));
      end
    end
    chk({tag, " mismatching word count"}, 32'(bad), 32'd0);
    chk("R4 no intrq on read", 32'(intrq), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s;
    void'($urandom(32'd4242));
    rstN = 1'b0; hrstN = 1'b1; cs0N = 1'b1; cs1N = 1'b1; da = '0;
    diowN = 1'b1; diorN = 1'b1; ddIn = '0; logRdEn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 log empty after reset", 32'(logValid), 32'd0);
    chk("R9 overflow clear after reset", 32'(logOverflow), 32'd0);
    chk("R5 intrq low after reset", 32'(intrq), 32'd0);
    chk("R7 bus undriven after reset", 32'(ddOe), 32'd0);
    regRead(3'd7, s);
    chk("R7 idle status", 32'(s), 32'(expStatus(1'b0, 1'b0)));

    // R1 hardware reset
    hrstPulse();
    drain();
    exp[0] = ent(4'd1, 8'h00);
    cmpLog("R1 hardware reset", 1);

    // R2 soft reset: rising SRST logs, a repeat with bit already set does not
    regWrite(1'b1, 3'd6, 16'h0004);
    regWrite(1'b1, 3'd6, 16'h0004);
    regWrite(1'b1, 3'd6, 16'h0000);
    drain();
    exp[0] = ent(4'd2, 8'h00);
    cmpLog("R2 soft reset", 1);

    // R3 / R5 write sectors with interrupts enabled
    writeSector(1'b0);
    drain();
    exp[0] = ent(4'd3, 8'h30); exp[1] = ent(4'd4, 8'h00);
    exp[2] = ent(4'd6, 8'h00); exp[3] = ent(4'd7, 8'h00);
    cmpLog("R3 write trace", 4);
    regRead(3'd7, s);
    chk("R7 status after write", 32'(s), 32'(expStatus(1'b0, 1'b0)));
    @(negedge clk);
    chk("R5 status read clears intrq", 32'(intrq), 32'd0);

    // R4 / R6 read back
    readSector("R6 readback");
    drain();
    exp[0] = ent(4'd3, 8'h20); exp[1] = ent(4'd5, 8'h00); exp[2] = ent(4'd7, 8'h00);
    cmpLog("R4 read trace", 3);

    // R5 masked interrupt, new data, read back again
    writeSector(1'b1);
    drain();
    exp[0] = ent(4'd3, 8'h30); exp[1] = ent(4'd4, 8'h00); exp[2] = ent(4'd7, 8'h00);
    cmpLog("R5 masked write trace", 3);
    readSector("R6 masked readback");
    drain();
    exp[0] = ent(4'd3, 8'h20); exp[1] = ent(4'd5, 8'h00); exp[2] = ent(4'd7, 8'h00);
    cmpLog("R4 second read trace", 3);

    // R8 other command codes
    for (int k = 0; k < 4; k++) begin
      logic [7:0] c;
      c = 8'($urandom());
      if (c == 8'h20 || c == 8'h30) c = 8'hEC;
      regWrite(1'b0, 3'd7, {8'h00, c});
      drain();
      exp[0] = ent(4'd3, c); exp[1] = ent(4'd7, 8'h00);
      cmpLog("R8 other command", 2);
      regRead(3'd7, s);
      chk("R8 idle after other command", 32'(s), 32'(expStatus(1'b0, 1'b0)));
    end

    // R9 overflow: 10 soft resets then 10 hard resets, no draining
    for (int k = 0; k < 10; k++) begin
      regWrite(1'b1, 3'd6, 16'h0004);
      regWrite(1'b1, 3'd6, 16'h0000);
    end
    for (int k = 0; k < 10; k++) hrstPulse();
    chk("R9 overflow set", 32'(logOverflow), 32'd1);
    drain();
    for (int k = 0; k < 16; k++) exp[k] = (k < 10) ? ent(4'd2, 8'h00) : ent(4'd1, 8'h00);
    cmpLog("R9 oldest kept", 16);
    chk("R9 overflow sticky after drain", 32'(logOverflow), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule